// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a programmable AND plane feeding a fixed OR plane. Twelve dedicated inputs and ten feedback signals each give a true and a complement line, for 44 array lines. A connection map, one row of 44 bits per product term, decides which lines each of the 133 product terms ANDs together. 120 of those terms feed ten OR gates in groups of unequal size. The remaining 13 terms come out on their own: one output-enable term per output, a global preset term, a global clear term and a clock term.

The map sits in configuration flops. It is written one row per clock through a word-wide load port, or wiped by a bulk-erase command, and only while a program-enable input is high. Between loads the array is purely combinational from `in_i` and `fb_i` to the outputs. The surrounding macrocell logic (registers, polarity, tristate) uses the sums and special terms; it is not part of this block.

Top module: `sop_logic_array`

## Requirements
- R1: After reset every connection is open, so with `prog_en_i` low all outputs read 1.
- R2: Row bit 2k connects the true form of signal k and bit 2k+1 its complement. Signals 0 to 11 are `in_i[0..11]` and signals 12 to 21 are `fb_i[0..9]`. A term is 1 exactly when every line it connects is 1.
- R3: A term with no connections evaluates to 1.
- R4: A term that connects both forms of any signal evaluates to 0.
- R5: `sum_o[o]` is the OR of consecutive term addresses starting at 0. Outputs 0 to 9 own 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 terms in turn, so output 4 ends at address 59 and output 9 ends at 119.
- R6: Term 120+i drives `oe_o[i]`, term 130 drives `preset_o`, term 131 drives `clear_o` and term 132 drives `clk_term_o`.
- R7: On a rising clock with `prog_en_i` and `wr_en_i` high, the row at `wr_addr_i` is replaced by `wr_data_i`. A 1 bit closes a connection.
- R8: While `prog_en_i` is low, `wr_en_i` and `erase_i` have no effect on the map.
- R9: On a rising clock with `prog_en_i` and `erase_i` high, every connection opens. An erase beats a write in the same cycle.
- R10: A write to an address of 133 or above changes nothing.
- R11: While `prog_en_i` is high, every output reads 1 (the erased value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Load clock |
| rst_ni | input | 1 | Active-low asynchronous reset, opens all connections |
| prog_en_i | input | 1 | Unlocks loading and forces outputs to 1 |
| erase_i | input | 1 | Bulk erase request |
| wr_en_i | input | 1 | Row write strobe |
| wr_addr_i | input | 8 | Product term address |
| wr_data_i | input | 44 | Connection row, 1 = closed |
| in_i | input | 12 | Dedicated inputs |
| fb_i | input | 10 | Feedback or pin signals |
| sum_o | output | 10 | OR sums |
| oe_o | output | 10 | Output-enable terms |
| preset_o | output | 1 | Global preset term |
| clear_o | output | 1 | Global clear term |
| clk_term_o | output | 1 | Clock term |

## Verification
Every cycle, the assertions check the following: an open row gives a true term, a contradictory row gives a false term, the map does not move while loading is locked or when the address is out of range, and an erase makes all outputs 1 once programming mode is left. Other behaviour needs the bench's scenarios and its reference model. That covers the line order within a row, the term allocation at the group edges (addresses 59, 60 and 119), the mapping of the special terms, and the replacement of rows on rewrite. It also covers the sums under many input patterns and random maps.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned N_IN      = 12;
  localparam int unsigned N_FB      = 10;
  localparam int unsigned TERM_MIN  = 8;
  localparam int unsigned TERM_STEP = 2;

  localparam int unsigned N_OUT   = N_FB;
  localparam int unsigned HALF    = N_OUT / 2;
  localparam int unsigned N_SIG   = N_IN + N_FB;
  localparam int unsigned N_LINES = 2 * N_SIG;

  // group sizes rise then fall symmetrically
  function automatic int unsigned term_count(int unsigned o);
    return (o < HALF) ? TERM_MIN + TERM_STEP * o
                      : TERM_MIN + TERM_STEP * (N_OUT - 1 - o);
  endfunction

  function automatic int unsigned term_base(int unsigned o);
    int unsigned b;
    b = 0;
    for (int unsigned k = 0; k < o; k++) b += term_count(k);
    return b;
  endfunction

  localparam int unsigned N_SUM      = term_base(N_OUT);
  localparam int unsigned OE_BASE    = N_SUM;
  localparam int unsigned PRESET_IDX = N_SUM + N_OUT;
  localparam int unsigned CLEAR_IDX  = PRESET_IDX + 1;
  localparam int unsigned CLK_IDX    = PRESET_IDX + 2;
  localparam int unsigned N_TERMS    = CLK_IDX + 1;
  localparam int unsigned ADDR_W     = $clog2(N_TERMS);

  typedef logic [N_LINES-1:0] row_t;

  function automatic logic has_pair(row_t v);
    logic r;
    r = 1'b0;
    for (int unsigned k = 0; k < N_SIG; k++) r |= v[2*k] & v[2*k+1];
    return r;
  endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
  import sop_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            prog_en_i,
  input  logic                            erase_i,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  row_t                            wr_data_i,
  output logic [N_TERMS-1:0][N_LINES-1:0] conn_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_TERMS - 1);

  logic addr_ok;
  assign addr_ok = (wr_addr_i <= LAST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_o <= '0;
    end else if (prog_en_i) begin
      if (erase_i)                conn_o <= '0;
      else if (wr_en_i && addr_ok) conn_o[wr_addr_i] <= wr_data_i;
    end
  end

  p_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_en_i |=> $stable(conn_o));

  p_bad_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && wr_en_i && !erase_i && (wr_addr_i > LAST_ADDR)) |=> $stable(conn_o));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_pkg::*;
(
  input  logic [N_IN-1:0]                 in_i,
  input  logic [N_FB-1:0]                 fb_i,
  input  logic [N_TERMS-1:0][N_LINES-1:0] conn_i,
  output logic [N_TERMS-1:0]              term_o
);
  logic [N_SIG-1:0] sig;
  row_t             lines;

  assign sig = {fb_i, in_i};

  for (genvar k = 0; k < N_SIG; k++) begin : g_line
    assign lines[2*k]   = sig[k];
    assign lines[2*k+1] = ~sig[k];
  end

  // a term fails only if some connected line is low
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign term_o[t] = ~|(conn_i[t] & ~lines);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
  import sop_pkg::*;
(
  input  logic [N_SUM-1:0] term_i,
  output logic [N_OUT-1:0] sum_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    localparam int unsigned BASE = term_base(o);
    localparam int unsigned CNT  = term_count(o);
    assign sum_o[o] = |term_i[BASE +: CNT];
  end
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_en_i,
  input  logic                erase_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [N_LINES-1:0]  wr_data_i,
  input  logic [N_IN-1:0]     in_i,
  input  logic [N_FB-1:0]     fb_i,
  output logic [N_OUT-1:0]    sum_o,
  output logic [N_OUT-1:0]    oe_o,
  output logic                preset_o,
  output logic                clear_o,
  output logic                clk_term_o
);
  logic [N_TERMS-1:0][N_LINES-1:0] conn;
  logic [N_TERMS-1:0]              term_all;
  logic [N_OUT-1:0]                sum_raw;

  sop_cfg_store u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_en_i (prog_en_i),
    .erase_i   (erase_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .conn_o    (conn)
  );

  sop_and_plane u_and (
    .in_i   (in_i),
    .fb_i   (fb_i),
    .conn_i (conn),
    .term_o (term_all)
  );

  sop_or_plane u_or (
    .term_i (term_all[N_SUM-1:0]),
    .sum_o  (sum_raw)
  );

  // outputs sit at erased value while loading
  assign sum_o      = prog_en_i ? '1   : sum_raw;
  assign oe_o       = prog_en_i ? '1   : term_all[OE_BASE +: N_OUT];
  assign preset_o   = prog_en_i | term_all[PRESET_IDX];
  assign clear_o    = prog_en_i | term_all[CLEAR_IDX];
  assign clk_term_o = prog_en_i | term_all[CLK_IDX];

  p_erase_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && erase_i) |=>
      (prog_en_i || (&sum_o && &oe_o && preset_o && clear_o && clk_term_o)));

  for (genvar t = 0; t < N_TERMS; t++) begin : g_chk
    p_open_true_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conn[t] == '0) |-> term_all[t]);
    p_contra_false_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      has_pair(conn[t]) |-> !term_all[t]);
  end
endmodule

// File: tb/sop_logic_array_tb_top.sv
module sop_logic_array_tb_top;
  localparam int NT = 133;

  typedef struct {
    logic [22:0] exp;
    string       req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_en = 1'b0, erase = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [43:0] wr_data = '0;
  logic [11:0] in_v = '0;
  logic [9:0]  fb_v = '0;
  logic [9:0]  sum, oe;
  logic        preset, clear, clk_term;

  logic [43:0] cfg_m [NT];
  sb_item_t    sb_q [$];
  sb_item_t    it;
  int          checks = 0, errors = 0, cycles = 0;
  bit          done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  sop_logic_array dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prog_en_i(prog_en), .erase_i(erase),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .in_i(in_v), .fb_i(fb_v), .sum_o(sum), .oe_o(oe),
    .preset_o(preset), .clear_o(clear), .clk_term_o(clk_term)
  );

  function automatic logic [22:0] model_out(logic [11:0] a, logic [9:0] f);
    logic [43:0] ln;
    logic [NT-1:0] tv;
    logic [22:0] r;
    int t;
    for (int k = 0; k < 22; k++) begin
      logic s;
      s = (k < 12) ? a[k] : f[k-12];
      ln[2*k] = s;
      ln[2*k+1] = ~s;
    end
    for (int i = 0; i < NT; i++) tv[i] = ((cfg_m[i] & ~ln) == 44'd0);
    r = '0;
    t = 0;
    for (int o = 0; o < 10; o++) begin
      int n;
      n = (o < 5) ? 8 + 2 * o : 26 - 2 * o;
      for (int j = 0; j < n; j++) begin
        r[o] = r[o] | tv[t];
        t++;
      end
    end
    for (int i = 0; i < 10; i++) r[10+i] = tv[120+i];
    r[20] = tv[130];
    r[21] = tv[131];
    r[22] = tv[132];
    return r;
  endfunction

  task automatic next_rnd(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic chk(logic [11:0] a, logic [9:0] f, logic pe, string req);
    sb_item_t x;
    in_v = a;
    fb_v = f;
    prog_en = pe;
    x.exp = pe ? '1 : model_out(a, f);
    x.req = req;
    sb_q.push_back(x);
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] addr, logic [43:0] data, logic pe, logic er);
    prog_en = pe;
    erase = er;
    wr_en = 1'b1;
    wr_addr = addr;
    wr_data = data;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    erase = 1'b0;
    prog_en = 1'b0;
    if (pe) begin
      if (er) for (int i = 0; i < NT; i++) cfg_m[i] = '0;
      else if (addr < NT) cfg_m[addr] = data;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      checks++;
      if ({clk_term, clear, preset, oe, sum} !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h exp %h", it.req,
                 {clk_term, clear, preset, oe, sum}, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 60000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] r1, r2, r3, r4, r5, r6;
    for (int i = 0; i < NT; i++) cfg_m[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1 reset: everything erased
    chk(12'h000, 10'h000, 1'b0, "R1");
    chk(12'hfff, 10'h3ff, 1'b0, "R1");
    // fill all rows with contradictory connections
    for (int t = 0; t < NT; t++) wr(8'(t), '1, 1'b1, 1'b0);
    chk(12'h5a5, 10'h2c3, 1'b0, "R4");
    chk(12'h000, 10'h3ff, 1'b0, "R4");
    // R11 outputs held while loading
    chk(12'h123, 10'h045, 1'b1, "R11");
    // R3 open term
    wr(8'd0, '0, 1'b1, 1'b0);
    chk(12'h3c0, 10'h111, 1'b0, "R3");
    // R2 line order: in0 true, in1 complement, fb0 true in output 1 term 8
    wr(8'd8, 44'h0_0100_0009, 1'b1, 1'b0);
    chk(12'h001, 10'h001, 1'b0, "R2");
    chk(12'h003, 10'h001, 1'b0, "R2");
    chk(12'h001, 10'h000, 1'b0, "R2");
    // R5 group edges: term 59 last of output 4, term 60 first of output 5
    wr(8'd59, 44'h0_0000_0010, 1'b1, 1'b0);
    chk(12'h004, 10'h000, 1'b0, "R5");
    chk(12'h000, 10'h000, 1'b0, "R5");
    wr(8'd60, 44'h0_0000_0040, 1'b1, 1'b0);
    chk(12'h008, 10'h000, 1'b0, "R5");
    wr(8'd119, '0, 1'b1, 1'b0);
    chk(12'h000, 10'h000, 1'b0, "R5");
    // R6 special terms
    wr(8'd125, '0, 1'b1, 1'b0);
    wr(8'd130, 44'h0_0040_0000, 1'b1, 1'b0);
    wr(8'd131, 44'h8_0000_0000, 1'b1, 1'b0);
    wr(8'd132, 44'h0_0000_0400, 1'b1, 1'b0);
    chk(12'h800, 10'h000, 1'b0, "R6");
    chk(12'h020, 10'h200, 1'b0, "R6");
    // R8 locked writes and erase ignored
    wr(8'd20, '0, 1'b0, 1'b0);
    chk(12'h000, 10'h000, 1'b0, "R8");
    wr(8'd0, '1, 1'b0, 1'b1);
    chk(12'hfff, 10'h3ff, 1'b0, "R8");
    // R10 out-of-range addresses
    wr(8'd133, '0, 1'b1, 1'b0);
    wr(8'd255, '0, 1'b1, 1'b0);
    chk(12'h000, 10'h000, 1'b0, "R10");
    // R7 write and rewrite
    wr(8'd20, '0, 1'b1, 1'b0);
    chk(12'h000, 10'h000, 1'b0, "R7");
    wr(8'd20, '1, 1'b1, 1'b0);
    chk(12'h000, 10'h000, 1'b0, "R7");
    // random sparse maps under random inputs (R2, R5)
    for (int i = 0; i < 40; i++) begin
      next_rnd(r1); next_rnd(r2); next_rnd(r3);
      next_rnd(r4); next_rnd(r5); next_rnd(r6);
      wr(8'(r1 % NT), {r2[11:0], r3} & {r4[11:0], r5} & {r6[11:0], r6 ^ r2}, 1'b1, 1'b0);
      next_rnd(r1);
      chk(r1[11:0], r1[21:12], 1'b0, "R5");
    end
    // R9 erase beats same-cycle write
    wr(8'd5, '1, 1'b1, 1'b1);
    chk(12'h0f0, 10'h0aa, 1'b0, "R9");
    chk(12'hf0f, 10'h155, 1'b0, "R9");
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule